// File: doc/BRIEF.md
# Programmable Synthesizer Divider and Phase/Frequency Detector

This block is the digital heart of a frequency synthesizer loop. A crystal tick stream is divided by one of six fixed reference ratios. An oscillator tick stream is divided by a programmable ratio of up to 15 bits. The falling edges of the two divided signals are compared in a tri-state phase/frequency detector. The detector drives a raise (UP) and a lower (DN) enable for an external charge pump, plus a high-impedance indication that is set whenever neither enable is active.

Both the oscillator and the crystal are modelled as single-cycle tick strobes on the one system clock, so the whole block lives in one clock domain. Test-mode decoding can force the pump into high impedance, or it can route both divided signals onto the two general-purpose port outputs. A two-bit pump-current code is formed from the current bit and the lowest test bit. A separate output carries the request to switch the tuning output off.

Top module: `pll_core`

## Requirements
- R1: The oscillator divider uses the `n_ratio` input clamped from below at 256. Any value from 0 to 255 acts as 256, and values from 256 to 32767 divide by exactly that value.
- R2: `ref_sel` chooses the reference ratio by code: 0→128, 1→80, 2→64, 3→32, 4→28, 5→24. Codes 6 and 7 also give 128.
- R3: A divided signal with ratio M is high for the first floor(M/2) ticks of its period and low for the rest. Its falling edge is the tick that moves its count from floor(M/2)−1 to floor(M/2).
- R4: When the divided-oscillator falling edge arrives and DN is not active, UP becomes active on the next clock. It stays active until the next reference falling edge clears it.
- R5: When the reference falling edge arrives and UP is not active, DN becomes active on the next clock. It stays active until the next divided-oscillator falling edge clears it.
- R6: Falling edges that fall in the same clock cycle leave UP and DN unchanged. `hiz` is 1 exactly when both UP and DN are inactive, and also in forced mode. After reset, UP=DN=0 and `hiz`=1.
- R7: UP and DN are never active in the same cycle.
- R8: Test code `test_bits`=3'b010 forces `up`=`dn`=0 and `hiz`=1, whatever the phase. The detector state keeps running underneath.
- R9: Test code 3'b100 drives `port0` with the divided oscillator and `port1` with the divided reference. Any other code drives `port0`/`port1` from `sw_port[0]`/`sw_port[1]`.
- R10: `pump_code` equals {`cp_bit`, `test_bits[0]`} and so selects one of four pump currents.
- R11: A new oscillator ratio or reference code takes effect only at the tick that ends the current period (count M−1 back to 0). Counters are never cut short. In synchronous reset the ratios load directly from the inputs.
- R12: `vt_off` follows `vt_off_bit` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| n_ratio | input | 15 | Requested oscillator divide ratio |
| ref_sel | input | 3 | Reference ratio code |
| test_bits | input | 3 | Test-mode code |
| cp_bit | input | 1 | Pump current range bit |
| vt_off_bit | input | 1 | Request to disable the tuning output |
| sw_port | input | 2 | Software values for the two port outputs |
| up | output | 1 | Charge-pump raise enable |
| dn | output | 1 | Charge-pump lower enable |
| hiz | output | 1 | Pump in high impedance |
| pump_code | output | 2 | Pump current selection |
| port0 | output | 1 | Port 0 output |
| port1 | output | 1 | Port 1 output |
| vt_off | output | 1 | Tuning-output disable to the analog stage |

## Verification
The two detector inputs can land in the same cycle: a divided-oscillator falling edge and a reference falling edge. That case has to leave both enables untouched. The bench provokes it by running both dividers with equal periods (ratio 256 on every clock against ratio 32 on every eighth clock) and sweeping the crystal strobe phase over all eight positions, so some phases coincide exactly and the others miss by a few cycles. A behavioural model with integer counters predicts every output on every clock, so a coincidence that wrongly sets an enable shows up as a mismatch on `up`, `dn` or `hiz`. Ratio reloads at period end are also mixed with running falling edges.

// File: rtl/pll_core.sv
module pll_core #(
  parameter int NW   = 15,
  parameter int RW   = 8,
  parameter int NMIN = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_tick,
  input  logic          osc_tick,
  input  logic [NW-1:0] n_ratio,
  input  logic [2:0]    ref_sel,
  input  logic [2:0]    test_bits,
  input  logic          cp_bit,
  input  logic          vt_off_bit,
  input  logic [1:0]    sw_port,
  output logic          up,
  output logic          dn,
  output logic          hiz,
  output logic [1:0]    pump_code,
  output logic          port0,
  output logic          port1,
  output logic          vt_off
);
  localparam logic [2:0] T_FORCE = 3'b010;
  localparam logic [2:0] T_ROUTE = 3'b100;

  function automatic logic [RW-1:0] ref_ratio(input logic [2:0] s);
    case (s)
      3'd1:    ref_ratio = RW'(80);
      3'd2:    ref_ratio = RW'(64);
      3'd3:    ref_ratio = RW'(32);
      3'd4:    ref_ratio = RW'(28);
      3'd5:    ref_ratio = RW'(24);
      default: ref_ratio = RW'(128);
    endcase
  endfunction

  logic [RW-1:0] r_act, rc;
  logic [NW-1:0] n_act, oc;
  logic          up_q, dn_q;

  wire [NW-1:0] n_load  = (n_ratio < NW'(NMIN)) ? NW'(NMIN) : n_ratio;
  wire          ref_end = xtal_tick && (rc == r_act - RW'(1));
  wire          osc_end = osc_tick && (oc == n_act - NW'(1));
  wire          ref_fe  = xtal_tick && (rc == (r_act >> 1) - RW'(1));
  wire          osc_fe  = osc_tick && (oc == (n_act >> 1) - NW'(1));
  wire          ref_div = rc < (r_act >> 1);
  wire          osc_div = oc < (n_act >> 1);
  wire          forced  = test_bits == T_FORCE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc    <= '0;
      r_act <= ref_ratio(ref_sel);
    end else if (xtal_tick) begin
      if (ref_end) begin
        rc    <= '0;
        r_act <= ref_ratio(ref_sel);
      end else begin
        rc <= rc + RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc    <= '0;
      n_act <= n_load;
    end else if (osc_tick) begin
      if (osc_end) begin
        oc    <= '0;
        n_act <= n_load;
      end else begin
        oc <= oc + NW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (osc_fe && !ref_fe) begin
      if (dn_q) dn_q <= 1'b0;
      else      up_q <= 1'b1;
    end else if (ref_fe && !osc_fe) begin
      if (up_q) up_q <= 1'b0;
      else      dn_q <= 1'b1;
    end
  end

  assign up        = up_q && !forced;
  assign dn        = dn_q && !forced;
  assign hiz       = forced || (!up_q && !dn_q);
  assign pump_code = {cp_bit, test_bits[0]};
  assign port0     = (test_bits == T_ROUTE) ? osc_div : sw_port[0];
  assign port1     = (test_bits == T_ROUTE) ? ref_div : sw_port[1];
  assign vt_off    = vt_off_bit;
endmodule

module pll_core_chk #(
  parameter int NW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up,
  input logic          dn,
  input logic          hiz,
  input logic          up_q,
  input logic          dn_q,
  input logic          osc_tick,
  input logic          xtal_tick,
  input logic [2:0]    test_bits,
  input logic [NW-1:0] n_act,
  input logic [NW-1:0] oc
);
  // R7
  up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));
  // R8
  force_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_bits == 3'b010) |-> (hiz && !up && !dn));
  // R4
  up_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(osc_tick));
  // R5
  dn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(xtal_tick));
  // R11
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_act) |-> $past(osc_tick && (oc == n_act - NW'(1))));
endmodule

bind pll_core pll_core_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .hiz(hiz),
  .up_q(up_q), .dn_q(dn_q), .osc_tick(osc_tick), .xtal_tick(xtal_tick),
  .test_bits(test_bits), .n_act(n_act), .oc(oc)
);

// File: tb/pll_core_bench.sv
module pll_core_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, xtal_tick = 1'b0, osc_tick = 1'b0;
  logic [14:0] n_ratio = 15'd256;
  logic [2:0]  ref_sel = 3'd3, test_bits = 3'd0;
  logic        cp_bit = 1'b0, vt_off_bit = 1'b0;
  logic [1:0]  sw_port = 2'b00;
  logic        up, dn, hiz, port0, port1, vt_off;
  logic [1:0]  pump_code;

  pll_core u_pll_core (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .osc_tick(osc_tick),
    .n_ratio(n_ratio), .ref_sel(ref_sel), .test_bits(test_bits), .cp_bit(cp_bit),
    .vt_off_bit(vt_off_bit), .sw_port(sw_port), .up(up), .dn(dn), .hiz(hiz),
    .pump_code(pump_code), .port0(port0), .port1(port1), .vt_off(vt_off)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R6";

  int rc, oc, rr, nn;
  bit mu, md;

  function automatic int ratio_of(input int s);
    case (s)
      0: return 128; 1: return 80; 2: return 64;
      3: return 32;  4: return 28; 5: return 24;
      default: return 128;
    endcase
  endfunction

  function automatic int clamp_n(input int n);
    return (n < 256) ? 256 : n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rc = 0; oc = 0; mu = 0; md = 0;
      rr = ratio_of(ref_sel); nn = clamp_n(n_ratio);
    end else begin
      bit rfe, ofe;
      rfe = xtal_tick && (rc == rr / 2 - 1);
      ofe = osc_tick && (oc == nn / 2 - 1);
      if (xtal_tick) begin
        if (rc == rr - 1) begin rc = 0; rr = ratio_of(ref_sel); end
        else rc++;
      end
      if (osc_tick) begin
        if (oc == nn - 1) begin oc = 0; nn = clamp_n(n_ratio); end
        else oc++;
      end
      if (ofe && !rfe) begin if (md) md = 0; else mu = 1; end
      else if (rfe && !ofe) begin if (mu) mu = 0; else md = 1; end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit f, route;
    f = (test_bits == 3'b010);
    route = (test_bits == 3'b100);
    chk({"R4 ", tag}, up, mu && !f);
    chk({"R5 ", tag}, dn, md && !f);
    chk({"R6 ", tag}, hiz, f || (!mu && !md));
    chk("R7", up && dn, 0);
    chk({"R9 ", tag}, port0, route ? (oc < nn / 2) : sw_port[0]);
    chk({"R9 ", tag}, port1, route ? (rc < rr / 2) : sw_port[1]);
    chk("R10", pump_code, {cp_bit, test_bits[0]});
    chk("R12", vt_off, vt_off_bit);
  endtask

  task automatic run(input int cycles, input int xp, input int xph, input int op);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      compare_all();
      xtal_tick = ((k % xp) == xph);
      osc_tick  = ((k % op) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk("R6 reset up", up, 0);
    chk("R6 reset dn", dn, 0);
    chk("R6 reset hiz", hiz, 1);

    // R6 R4 R5: equal periods, phase sweep provokes coincident edges
    tag = "R6 coincide R3";
    for (int ph = 0; ph < 8; ph++) begin
      rst_n = 1'b0; xtal_tick = 0; osc_tick = 0;
      @(negedge clk); rst_n = 1'b1;
      run(1300, 8, ph, 1);
    end

    // R4 oscillator fast: ref 128 ticks every 3 cycles vs N=256 every cycle
    tag = "R4 lead";
    ref_sel = 3'd0; n_ratio = 15'd256;
    run(3000, 3, 0, 1);

    // R5 oscillator slow; R11 reload at period end
    tag = "R5 lag R11";
    ref_sel = 3'd5; n_ratio = 15'd300;
    run(3000, 8, 1, 2);

    // R1 clamp and R2 ratios routed to ports, R3 waveform
    test_bits = 3'b100;
    n_ratio = 15'd100;
    for (int s = 0; s < 8; s++) begin
      tag = "R1 R2 R3 R11";
      ref_sel = 3'(s);
      run(1500, 2, 1, 1);
    end
    n_ratio = 15'd257;
    tag = "R1 odd R3";
    run(1500, 4, 2, 1);

    // R8 forced high impedance while detector keeps running
    tag = "R8";
    test_bits = 3'b010; ref_sel = 3'd3; n_ratio = 15'd256;
    run(2500, 3, 0, 1);
    test_bits = 3'b000;
    tag = "R8 release";
    run(1500, 3, 0, 1);

    // R9 R10 R12 software ports, pump codes, tuning disable
    for (int t = 0; t < 8; t++) begin
      tag = "R9 R10 R12";
      test_bits = 3'(t); cp_bit = t[1]; vt_off_bit = t[0]; sw_port = 2'(t + 1);
      run(300, 5, 2, 1);
    end

    // R11 ratio changes mid-period
    test_bits = 3'b100;
    for (int j = 0; j < 6; j++) begin
      tag = "R11 change";
      n_ratio = 15'(260 + 37 * j); ref_sel = 3'(j);
      run(777, 2, 0, 1);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule